// File: doc/BRIEF.md
# SD Card SPI Start-Up Sequencer

This block takes an SD card from power-up to the point where block transfers over SPI can begin. It does not shift bits itself. It issues requests to a separate command engine, one at a time, and reads back the R1 status byte and, where one exists, a 32-bit payload. It owns the card chip-select and the SPI clock divider setting. It also owns the timing rules of the start-up procedure: the wake-up clocks, the pause between reset attempts, and the limit on how long the card may stay busy initialising.

A `start` pulse runs the whole procedure. When the card is ready, `done` rises, the divider switches from the slow start-up rate to the transfer rate, and `card_type` holds the class of card that was found. On any failure, `error` rises and `err_code` gives the reason. A later `start` pulse runs the procedure again from the beginning.

Top module: `sd_init_seq`

## Requirements
- R1: After `start`, the first request has `req_fill`=1 and `req_arg`=FILL_BYTES (10), with `cs_n` high. While the procedure runs, `sck_half_div` = ceil(CLK_HZ / (2·INIT_HZ)).
- R2: The reset command (index 0, argument 0, one-byte reply) succeeds only on an R1 of exactly 0x01. Any other reply is retried, up to CMD0_TRIES attempts in total, and each retry follows at least MS_TICKS clock cycles after the previous reply.
- R3: If every reset attempt fails, `error`=1, `err_code`=1 (no device) and `card_type`=0 (none).
- R4: The interface check is index 8 with argument 0x1AA and a 5-byte reply. If R1 bit 2 (illegal command) is set, the card is treated as v1. Otherwise the payload bits [11:0] must equal 0x1AA, or the procedure stops with `err_code`=2 (unusable) and `card_type`=4 (unknown).
- R5: The OCR read is index 58 with argument 0 and a 5-byte reply. If payload bit 20 (3.3 V window) is clear, the procedure stops with `err_code`=2 and `card_type`=4.
- R6: The operating-condition command is index 41 with `req_app`=1. Its argument is 0x4000_0000 (bit 30 set) for v2 cards and 0 for v1 cards. It is reissued while R1 equals 0x01 and ends when R1 equals 0x00.
- R7: If the card is still idle on a reply that arrives TIMEOUT_MS milliseconds (MS_TICKS cycles each) or more after the first operating-condition request, the procedure stops with `err_code`=3 (timeout) and `card_type`=4.
- R8: A v2 card gets a second OCR read. Payload bit 30 set gives `card_type`=3 (v2 high capacity); clear gives 2 (v2 standard). A v1 card skips this read and gets `card_type`=1.
- R9: The last request is index 59 with argument 0. On an R1 of 0x00 the block sets `done`=1, `fast_clk_sel`=1, `cs_n`=1 and `sck_half_div` = ceil(CLK_HZ / (2·min(XFER_HZ, 25 MHz))).
- R10: An R1 with bit 7 set or any of bits 6..1 set stops the procedure with `err_code`=4 (rejected) and `card_type`=4. This applies to the OCR reads, the operating-condition command and the CRC-off command. It also applies to the interface check when bit 2 is clear.
- R11: `cs_n` is low exactly while a command request (not a fill request) is outstanding. A request holds its fields stable until `rsp_valid` answers it.
- R12: After reset, `done`, `error`, `req_valid` and `fast_clk_sel` are 0, `cs_n` is 1, and `card_type` and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the start-up procedure (used when idle, done or failed) |
| req_valid | output | 1 | A request to the command engine is outstanding |
| req_fill | output | 1 | Request is fill bytes with chip-select high; byte count in req_arg |
| req_idx | output | 6 | Command index |
| req_arg | output | 32 | Command argument, or fill byte count |
| req_app | output | 1 | Precede the command with the application-command prefix |
| req_long | output | 1 | Expect a 5-byte reply (R1 plus 32-bit payload) |
| rsp_valid | input | 1 | One-cycle answer to the outstanding request |
| rsp_r1 | input | 8 | R1 status byte (0xFF when the card gave no reply) |
| rsp_data | input | 32 | Payload of a 5-byte reply |
| cs_n | output | 1 | Card chip-select, active low |
| sck_half_div | output | 16 | SPI clock half-period in system clock cycles |
| fast_clk_sel | output | 1 | Transfer clock rate selected |
| done | output | 1 | Card ready for transfers |
| error | output | 1 | Procedure failed |
| err_code | output | 3 | 0 ok, 1 no device, 2 unusable, 3 timeout, 4 rejected |
| card_type | output | 3 | 0 none, 1 v1, 2 v2 standard, 3 v2 high capacity, 4 unknown |

## Verification
The bench builds the block with CLK_HZ = 100 MHz, INIT_HZ = 400 kHz and XFER_HZ = 50 MHz. These values give a slow divider of 125 and a capped fast divider of 2, so the 25 MHz cap changes the visible result. MS_TICKS is lowered to 200 and TIMEOUT_MS to 3. With these settings the reset-retry pauses, the exhausted-retry case and the busy-card timeout all run in a few thousand cycles, where the real millisecond scale would be out of reach.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE, ST_RST, ST_PAUSE, ST_IFC, ST_OCR,
    ST_OPC, ST_CCS, ST_CRC, ST_DONE, ST_FAIL
  } seq_state_e;

  typedef enum logic [2:0] {
    CK_NONE = 3'd0, CK_V1 = 3'd1, CK_V2SC = 3'd2, CK_V2HC = 3'd3, CK_UNKNOWN = 3'd4
  } card_kind_e;

  typedef enum logic [2:0] {
    FT_OK = 3'd0, FT_NODEV = 3'd1, FT_UNUSABLE = 3'd2, FT_TIMEOUT = 3'd3, FT_REJECT = 3'd4
  } fault_e;

  localparam logic [5:0]  IDX_RESET   = 6'd0;
  localparam logic [5:0]  IDX_IFCOND  = 6'd8;
  localparam logic [5:0]  IDX_OPCOND  = 6'd41;
  localparam logic [5:0]  IDX_OCR     = 6'd58;
  localparam logic [5:0]  IDX_CRCSW   = 6'd59;
  localparam logic [11:0] IFC_ECHO    = 12'h1AA;
  localparam int          HCS_POS     = 30;
  localparam int          WIN33_POS   = 20;
  localparam int          CCS_POS     = 30;
  localparam int          XFER_MAX_HZ = 25_000_000;

  function automatic int ceil_half_div(input int clk_hz, input int sck_hz);
    int q;
    q = (clk_hz + 2 * sck_hz - 1) / (2 * sck_hz);
    return (q < 1) ? 1 : q;
  endfunction

endpackage

// File: rtl/sd_init_ms_timer.sv
module sd_init_ms_timer #(
  parameter int MS_TICKS = 100_000,
  parameter int MS_W     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic [MS_W-1:0] ms_cnt
);
  localparam int PW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(MS_TICKS - 1);

  logic [PW-1:0]   pre_q, pre_d;
  logic [MS_W-1:0] ms_q, ms_d;

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (!run) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (pre_q == PRE_LAST) begin
      pre_d = '0;
      if (ms_q != '1) ms_d = ms_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  assign ms_cnt = ms_q;
endmodule

// File: rtl/sd_init_r1_decode.sv
module sd_init_r1_decode (
  input  logic [7:0] r1,
  output logic       idle_only,
  output logic       ready,
  output logic       illegal,
  output logic       fault
);
  always_comb begin
    idle_only = (r1 == 8'h01);
    ready     = (r1 == 8'h00);
    illegal   = r1[2];
    fault     = r1[7] | (|r1[6:1]);
  end
endmodule

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
  import sd_init_pkg::*;
#(
  parameter int TIMEOUT_MS = 5000,
  parameter int CMD0_TRIES = 5,
  parameter int FILL_BYTES = 10,
  parameter int MS_W       = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rsp_valid,
  input  logic [31:0]     rsp_data,
  input  logic            r1_idle_only,
  input  logic            r1_ready,
  input  logic            r1_illegal,
  input  logic            r1_fault,
  input  logic [MS_W-1:0] ms_cnt,
  output logic            ms_run,
  output logic            req_valid,
  output logic            req_fill,
  output logic [5:0]      req_idx,
  output logic [31:0]     req_arg,
  output logic            req_app,
  output logic            req_long,
  output logic            cs_n,
  output logic            fast_sel,
  output logic            done,
  output logic            error,
  output logic [2:0]      err_code,
  output logic [2:0]      card_type
);
  localparam int RW = $clog2(CMD0_TRIES + 1);
  localparam logic [RW-1:0]   LAST_TRY  = RW'(CMD0_TRIES - 1);
  localparam logic [MS_W-1:0] LIMIT_MS  = MS_W'(TIMEOUT_MS);

  seq_state_e      state_q, state_d;
  card_kind_e      kind_q, kind_d;
  fault_e          fault_q, fault_d;
  logic [RW-1:0]   tries_q, tries_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    fault_d = fault_q;
    tries_d = tries_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          state_d = ST_WAKE;
          kind_d  = CK_NONE;
          fault_d = FT_OK;
          tries_d = '0;
        end
      end
      ST_WAKE: if (rsp_valid) state_d = ST_RST;
      ST_RST: begin
        if (rsp_valid) begin
          if (r1_idle_only) begin
            state_d = ST_IFC;
          end else if (tries_q == LAST_TRY) begin
            state_d = ST_FAIL;
            fault_d = FT_NODEV;
            kind_d  = CK_NONE;
          end else begin
            tries_d = tries_q + 1'b1;
            state_d = ST_PAUSE;
          end
        end
      end
      ST_PAUSE: if (ms_cnt != '0) state_d = ST_RST;
      ST_IFC: begin
        if (rsp_valid) begin
          if (r1_illegal) begin
            kind_d  = CK_V1;
            state_d = ST_OCR;
          end else if (r1_fault) begin
            state_d = ST_FAIL;
            fault_d = FT_REJECT;
            kind_d  = CK_UNKNOWN;
          end else if (rsp_data[11:0] == IFC_ECHO) begin
            kind_d  = CK_V2SC;
            state_d = ST_OCR;
          end else begin
            state_d = ST_FAIL;
            fault_d = FT_UNUSABLE;
            kind_d  = CK_UNKNOWN;
          end
        end
      end
      ST_OCR: begin
        if (rsp_valid) begin
          if (r1_fault) begin
            state_d = ST_FAIL;
            fault_d = FT_REJECT;
            kind_d  = CK_UNKNOWN;
          end else if (!rsp_data[WIN33_POS]) begin
            state_d = ST_FAIL;
            fault_d = FT_UNUSABLE;
            kind_d  = CK_UNKNOWN;
          end else begin
            state_d = ST_OPC;
          end
        end
      end
      ST_OPC: begin
        if (rsp_valid) begin
          if (r1_ready) begin
            state_d = (kind_q == CK_V2SC) ? ST_CCS : ST_CRC;
          end else if (r1_fault) begin
            state_d = ST_FAIL;
            fault_d = FT_REJECT;
            kind_d  = CK_UNKNOWN;
          end else if (ms_cnt >= LIMIT_MS) begin
            state_d = ST_FAIL;
            fault_d = FT_TIMEOUT;
            kind_d  = CK_UNKNOWN;
          end
        end
      end
      ST_CCS: begin
        if (rsp_valid) begin
          if (r1_fault) begin
            state_d = ST_FAIL;
            fault_d = FT_REJECT;
            kind_d  = CK_UNKNOWN;
          end else begin
            kind_d  = rsp_data[CCS_POS] ? CK_V2HC : CK_V2SC;
            state_d = ST_CRC;
          end
        end
      end
      ST_CRC: begin
        if (rsp_valid) begin
          if (r1_fault) begin
            state_d = ST_FAIL;
            fault_d = FT_REJECT;
            kind_d  = CK_UNKNOWN;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= CK_NONE;
      fault_q <= FT_OK;
      tries_q <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      fault_q <= fault_d;
      tries_q <= tries_d;
    end
  end

  // request decode
  always_comb begin
    req_valid = 1'b1;
    req_fill  = 1'b0;
    req_idx   = IDX_RESET;
    req_arg   = '0;
    req_app   = 1'b0;
    req_long  = 1'b0;
    unique case (state_q)
      ST_WAKE: begin
        req_fill = 1'b1;
        req_arg  = 32'(FILL_BYTES);
      end
      ST_RST: req_idx = IDX_RESET;
      ST_IFC: begin
        req_idx  = IDX_IFCOND;
        req_arg  = {20'd0, IFC_ECHO};
        req_long = 1'b1;
      end
      ST_OCR, ST_CCS: begin
        req_idx  = IDX_OCR;
        req_long = 1'b1;
      end
      ST_OPC: begin
        req_idx          = IDX_OPCOND;
        req_app          = 1'b1;
        req_arg[HCS_POS] = (kind_q == CK_V2SC);
      end
      ST_CRC: req_idx = IDX_CRCSW;
      default: req_valid = 1'b0;
    endcase
  end

  assign ms_run    = (state_q == ST_PAUSE) || (state_q == ST_OPC);
  assign cs_n      = !(req_valid && !req_fill);
  assign fast_sel  = (state_q == ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign error     = (state_q == ST_FAIL);
  assign err_code  = fault_q;
  assign card_type = kind_q;
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sd_init_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int INIT_HZ    = 400_000,
  parameter int XFER_HZ    = 25_000_000,
  parameter int MS_TICKS   = CLK_HZ / 1000,
  parameter int TIMEOUT_MS = 5000,
  parameter int CMD0_TRIES = 5,
  parameter int FILL_BYTES = 10,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             req_valid,
  output logic             req_fill,
  output logic [5:0]       req_idx,
  output logic [31:0]      req_arg,
  output logic             req_app,
  output logic             req_long,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_r1,
  input  logic [31:0]      rsp_data,
  output logic             cs_n,
  output logic [DIV_W-1:0] sck_half_div,
  output logic             fast_clk_sel,
  output logic             done,
  output logic             error,
  output logic [2:0]       err_code,
  output logic [2:0]       card_type
);
  localparam int MS_W        = $clog2(TIMEOUT_MS + 2);
  localparam int XFER_CAPPED = (XFER_HZ > XFER_MAX_HZ) ? XFER_MAX_HZ : XFER_HZ;
  localparam int SLOW_DIV    = ceil_half_div(CLK_HZ, INIT_HZ);
  localparam int FAST_DIV    = ceil_half_div(CLK_HZ, XFER_CAPPED);

  logic            r1_idle_only, r1_ready, r1_illegal, r1_fault;
  logic            ms_run;
  logic [MS_W-1:0] ms_cnt;

  sd_init_r1_decode u_r1 (
    .r1        (rsp_r1),
    .idle_only (r1_idle_only),
    .ready     (r1_ready),
    .illegal   (r1_illegal),
    .fault     (r1_fault)
  );

  sd_init_ms_timer #(.MS_TICKS(MS_TICKS), .MS_W(MS_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ms_run),
    .ms_cnt (ms_cnt)
  );

  sd_init_fsm #(
    .TIMEOUT_MS (TIMEOUT_MS),
    .CMD0_TRIES (CMD0_TRIES),
    .FILL_BYTES (FILL_BYTES),
    .MS_W       (MS_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .r1_idle_only (r1_idle_only),
    .r1_ready     (r1_ready),
    .r1_illegal   (r1_illegal),
    .r1_fault     (r1_fault),
    .ms_cnt       (ms_cnt),
    .ms_run       (ms_run),
    .req_valid    (req_valid),
    .req_fill     (req_fill),
    .req_idx      (req_idx),
    .req_arg      (req_arg),
    .req_app      (req_app),
    .req_long     (req_long),
    .cs_n         (cs_n),
    .fast_sel     (fast_clk_sel),
    .done         (done),
    .error        (error),
    .err_code     (err_code),
    .card_type    (card_type)
  );

  assign sck_half_div = fast_clk_sel ? DIV_W'(FAST_DIV) : DIV_W'(SLOW_DIV);
endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        req_valid,
  input logic        req_fill,
  input logic [5:0]  req_idx,
  input logic [31:0] req_arg,
  input logic        req_app,
  input logic        req_long,
  input logic        rsp_valid,
  input logic        cs_n,
  input logic        fast_clk_sel,
  input logic        done,
  input logic        error,
  input logic [2:0]  err_code,
  input logic [2:0]  card_type
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_idx) && $stable(req_arg) && $stable(req_app)); // R11

  AST_RSP_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && req_valid && !req_fill |-> !cs_n); // R11

  AST_WAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) && start |=> req_valid && req_fill && cs_n); // R1

  AST_IFC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_fill && req_idx == 6'd8 |-> req_arg == 32'h1AA && req_long); // R4

  AST_HCS_V2_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_idx == 6'd41 |-> req_app && (req_arg[30] == (card_type == 3'd2))); // R6

  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R9

  AST_FAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_sel |-> done && cs_n && card_type >= 3'd1 && card_type <= 3'd3); // R9

  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> err_code != 3'd0 && (err_code == 3'd1) == (card_type == 3'd0)); // R3
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .req_valid    (req_valid),
  .req_fill     (req_fill),
  .req_idx      (req_idx),
  .req_arg      (req_arg),
  .req_app      (req_app),
  .req_long     (req_long),
  .rsp_valid    (rsp_valid),
  .cs_n         (cs_n),
  .fast_clk_sel (fast_clk_sel),
  .done         (done),
  .error        (error),
  .err_code     (err_code),
  .card_type    (card_type)
);

// File: tb/sd_init_seq_bench.sv
module sd_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MS_TICKS   = 200;
  localparam int TIMEOUT_MS = 3;
  localparam int LAT        = 4;
  localparam int SLOW_EXP   = 125;
  localparam int FAST_EXP   = 2;

  typedef struct packed {
    logic        fill;
    logic        app;
    logic        lng;
    logic [5:0]  idx;
    logic [31:0] arg;
  } req_t;

  logic        clk, rst_n, start;
  logic        req_valid, req_fill, req_app, req_long;
  logic [5:0]  req_idx;
  logic [31:0] req_arg;
  logic        rsp_valid;
  logic [7:0]  rsp_r1;
  logic [31:0] rsp_data;
  logic        cs_n, fast_clk_sel, done, error;
  logic [15:0] sck_half_div;
  logic [2:0]  err_code, card_type;

  sd_init_seq #(
    .CLK_HZ(100_000_000), .INIT_HZ(400_000), .XFER_HZ(50_000_000),
    .MS_TICKS(MS_TICKS), .TIMEOUT_MS(TIMEOUT_MS), .CMD0_TRIES(5), .FILL_BYTES(10)
  ) u_sd_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_fill(req_fill), .req_idx(req_idx), .req_arg(req_arg),
    .req_app(req_app), .req_long(req_long),
    .rsp_valid(rsp_valid), .rsp_r1(rsp_r1), .rsp_data(rsp_data),
    .cs_n(cs_n), .sck_half_div(sck_half_div), .fast_clk_sel(fast_clk_sel),
    .done(done), .error(error), .err_code(err_code), .card_type(card_type)
  );

  int n_checks = 0, n_fails = 0;
  int cyc = 0;
  bit reported = 0;
  int scen = 0;
  bit sticky = 0;
  int n_cmd0 = 0, n_acmd = 0, n_ocr = 0;
  int last_cmd0_rsp = 0, first_acmd_cyc = 0;
  req_t exp_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  function automatic string tag_of(input req_t r);
    if (r.fill) return "R1 fill request";
    case (r.idx)
      6'd0:  return "R2 reset request";
      6'd8:  return "R4 interface check request";
      6'd58: return "R5/R8 OCR request";
      6'd41: return "R6 operating condition request";
      6'd59: return "R9 CRC-off request";
      default: return "R11 unknown request";
    endcase
  endfunction

  function automatic req_t mk(input bit fill, input bit app, input bit lng, input int idx, input logic [31:0] arg);
    req_t r;
    r.fill = fill; r.app = app; r.lng = lng; r.idx = 6'(idx); r.arg = arg;
    return r;
  endfunction

  // reference card: reply per scenario and request
  task automatic card_reply(input req_t r, output logic [7:0] r1, output logic [31:0] d);
    r1 = 8'h00; d = 32'h0;
    if (r.fill) return;
    case (r.idx)
      6'd0: r1 = (scen == 2 || (scen == 1 && n_cmd0 < 2)) ? 8'hFF : 8'h01;
      6'd8: begin
        if (scen == 1) r1 = 8'h05;
        else begin r1 = 8'h01; d = (scen == 3) ? 32'h0000_01A5 : 32'h0000_01AA; end
      end
      6'd58: begin
        if (n_ocr == 0) begin r1 = 8'h01; d = (scen == 4) ? 32'h00EF_8000 : 32'h00FF_8000; end
        else begin r1 = 8'h00; d = (scen == 6) ? 32'h80FF_8000 : 32'hC0FF_8000; end
      end
      6'd41: r1 = (scen == 5 || n_acmd < 2) ? 8'h01 : 8'h00;
      6'd59: r1 = (scen == 7) ? 8'h04 : 8'h00;
      default: r1 = 8'hFF;
    endcase
  endtask

  // responder: compares each request against the expected queue
  initial begin
    req_t got;
    logic [7:0] r1;
    logic [31:0] d;
    rsp_valid = 1'b0; rsp_r1 = 8'hFF; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        got = mk(req_fill, req_app, req_long, int'(req_idx), req_arg);
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected request", 64'(got), 64'h0);
        else begin
          check(got == exp_q[0], tag_of(got), 64'(got), 64'(exp_q[0]));
          if (!(sticky && exp_q.size() == 1)) void'(exp_q.pop_front());
        end
        if (got.fill) check(sck_half_div == 16'(SLOW_EXP), "R1 slow divider", 64'(sck_half_div), 64'(SLOW_EXP));
        if (!got.fill && got.idx == 6'd0 && n_cmd0 > 0)
          check(cyc - last_cmd0_rsp >= MS_TICKS, "R2 retry pause", 64'(cyc - last_cmd0_rsp), 64'(MS_TICKS));
        if (!got.fill && got.idx == 6'd41 && n_acmd == 0) first_acmd_cyc = cyc;
        card_reply(got, r1, d);
        repeat (LAT) @(negedge clk);
        rsp_r1 = r1; rsp_data = d; rsp_valid = 1'b1;
        if (!got.fill) begin
          if (got.idx == 6'd0) begin n_cmd0++; last_cmd0_rsp = cyc; end
          if (got.idx == 6'd41) n_acmd++;
          if (got.idx == 6'd58) n_ocr++;
        end
        @(negedge clk);
        rsp_valid = 1'b0; rsp_r1 = 8'hFF; rsp_data = '0;
      end
    end
  end

  // per-clock chip-select comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) check(cs_n == !(req_valid && !req_fill), "R11 chip-select", 64'(cs_n), 64'(!(req_valid && !req_fill)));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
    report();
  end

  task automatic push_front_part(input int n_rst);
    exp_q.push_back(mk(1, 0, 0, 0, 32'd10));
    for (int i = 0; i < n_rst; i++) exp_q.push_back(mk(0, 0, 0, 0, 32'h0));
  endtask

  task automatic run_scen(input int s, input logic [2:0] e_type, input logic [2:0] e_err, input bit e_done);
    int guard;
    scen = s; n_cmd0 = 0; n_acmd = 0; n_ocr = 0; sticky = 0;
    exp_q.delete();
    case (s)
      0, 6, 7: begin
        push_front_part(1);
        exp_q.push_back(mk(0, 0, 1, 8, 32'h1AA));
        exp_q.push_back(mk(0, 0, 1, 58, 32'h0));
        for (int i = 0; i < 3; i++) exp_q.push_back(mk(0, 1, 0, 41, 32'h4000_0000));
        exp_q.push_back(mk(0, 0, 1, 58, 32'h0));
        exp_q.push_back(mk(0, 0, 0, 59, 32'h0));
      end
      1: begin
        push_front_part(3);
        exp_q.push_back(mk(0, 0, 1, 8, 32'h1AA));
        exp_q.push_back(mk(0, 0, 1, 58, 32'h0));
        for (int i = 0; i < 3; i++) exp_q.push_back(mk(0, 1, 0, 41, 32'h0));
        exp_q.push_back(mk(0, 0, 0, 59, 32'h0));
      end
      2: push_front_part(5);
      3: begin push_front_part(1); exp_q.push_back(mk(0, 0, 1, 8, 32'h1AA)); end
      4, 5: begin
        push_front_part(1);
        exp_q.push_back(mk(0, 0, 1, 8, 32'h1AA));
        exp_q.push_back(mk(0, 0, 1, 58, 32'h0));
        if (s == 5) begin exp_q.push_back(mk(0, 1, 0, 41, 32'h4000_0000)); sticky = 1; end
      end
      default: ;
    endcase
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!(done || error) && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(card_type == e_type, (s == 2) ? "R3 card type" : "R8 card type", 64'(card_type), 64'(e_type));
    check(err_code == e_err, (s == 5) ? "R7 fault code" : (s == 7) ? "R10 fault code" : "R5 fault code",
          64'(err_code), 64'(e_err));
    check(done == e_done && error == !e_done, "R9 end flags", 64'({done, error}), 64'({e_done, !e_done}));
    check(fast_clk_sel == e_done, "R9 fast select", 64'(fast_clk_sel), 64'(e_done));
    check(sck_half_div == 16'(e_done ? FAST_EXP : SLOW_EXP), "R9 divider",
          64'(sck_half_div), 64'(e_done ? FAST_EXP : SLOW_EXP));
    check(cs_n == 1'b1, "R11 chip-select released", 64'(cs_n), 64'h1);
    check(exp_q.size() == (sticky ? 1 : 0), "R2 request count", 64'(exp_q.size()), 64'(sticky ? 1 : 0));
    if (s == 5) check(cyc - first_acmd_cyc >= TIMEOUT_MS * MS_TICKS, "R7 timeout length",
                      64'(cyc - first_acmd_cyc), 64'(TIMEOUT_MS * MS_TICKS));
    if (s == 2) check(n_cmd0 == 5, "R3 reset attempts", 64'(n_cmd0), 64'd5);
  endtask

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 0 && error == 0 && req_valid == 0 && fast_clk_sel == 0, "R12 reset flags",
          64'({done, error, req_valid, fast_clk_sel}), 64'h0);
    check(cs_n == 1'b1, "R12 reset chip-select", 64'(cs_n), 64'h1);
    check(card_type == 3'd0 && err_code == 3'd0, "R12 reset codes", 64'({card_type, err_code}), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0, "R12 idle without start", 64'(req_valid), 64'h0);
    run_scen(0, 3'd3, 3'd0, 1'b1);  // R8 v2 high capacity
    run_scen(1, 3'd1, 3'd0, 1'b1);  // R2 R4 R6 v1 path with two lost resets
    run_scen(2, 3'd0, 3'd1, 1'b0);  // R3 no device
    run_scen(3, 3'd4, 3'd2, 1'b0);  // R4 echo mismatch
    run_scen(4, 3'd4, 3'd2, 1'b0);  // R5 no 3.3 V window
    run_scen(5, 3'd4, 3'd3, 1'b0);  // R7 busy card timeout
    run_scen(6, 3'd2, 3'd0, 1'b1);  // R8 v2 standard capacity
    run_scen(7, 3'd4, 3'd4, 1'b0);  // R10 rejected CRC-off
    repeat (5) @(negedge clk);
    report();
  end
endmodule